// File: doc/BRIEF.md
# Spur-Reduced Third-Order Cascaded Noise-Shaping Modulator

This block chooses the divider modulus in a fractional-N synthesizer. On each enabled clock it takes an unsigned fractional word of `FRAC_W` bits and returns a small signed integer. Over time those integers average to the fraction, and their quantization noise is pushed to high frequencies. The modulus is M = 2^FRAC_W.

Three first-order accumulator stages are cascaded, and a difference network combines their carries.

- **Entry stage.** Its accumulator also adds `FB_CONST` times its own previous carry. This makes the stage repeat every M−`FB_CONST` steps for any constant input. The constant is chosen so that this count is prime.
- **Stages two and three.** Each one accumulates the residue of the stage before it, plus that stage's carry at the least significant bit.
- **Overall period.** For a constant input, the output repeats every M²·(M−`FB_CONST`) steps. This keeps tones out of the output spectrum.

Top module: `mash3_spur_mod`

## Requirements
- R1: A synchronous active-high `rst` clears every accumulator, carry and delay register. `mod_out` reads 0 after the first clock with `rst` high, and stays 0 until the first enabled step after release.
- R2: The entry stage is a `FRAC_W`-bit accumulator.
  - It adds the input word plus `FB_CONST` times its previous carry.
  - Its carry is 1 when the sum reaches M, and the residue is the sum minus M times the carry.
  - Inputs up to M−1−`FB_CONST` are accepted.
  - When `FB_CONST` is 1, the feedback is realised as a carry-in.
- R3: Stages two and three each accumulate the previous stage's residue plus that stage's carry added at bit 0.
- R4: `mod_out` is a 4-bit two's-complement value equal to c1[k] + (c2[k] − c2[k−1]) + (c3[k] − 2·c3[k−1] + c3[k−2]), with the three carry paths aligned in time. It always lies in −3..+4.
- R5: For a constant input, the `mod_out` sequence repeats with period M²·(M−`FB_CONST`) once the first period has passed.
- R6: Over a full period, the sum of `mod_out` equals the input times M², which is an average of input/(M−`FB_CONST`). Over any long window, the sum times (M−`FB_CONST`) stays within 8·M of input times window length.
- R7: A zero input from the reset state gives `mod_out` = 0 on every step.
- R8: With `en` low, all state and `mod_out` hold. Resuming continues the sequence exactly as if no pause occurred.
- R9: Asserting reset in mid-run and releasing it again restarts the identical output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the modulator by one step |
| frac_word | input | FRAC_W | Unsigned fractional input, at most M−1−FB_CONST |
| mod_out | output | 4 | Signed divider offset, −3..+4 |

## Verification
The assertions assume that `frac_word` never exceeds M−1−`FB_CONST`. That bound is what keeps every accumulator addend at or below M, so a single carry per step is always enough.

The stimulus stays inside this bound: the largest value applied is exactly M−1−`FB_CONST`. Inputs are changed only while reset is high or between runs, so each period and average measurement sees a constant word.

// File: rtl/mash3_pkg.sv
package mash3_pkg;
   localparam int unsigned STAGES = 3;
   localparam int unsigned OUT_W  = 4;
   typedef logic signed [OUT_W-1:0] mash_out_t;
endpackage

// File: rtl/mash_acc_cell.sv
module mash_acc_cell #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W:0]   addend,
   output logic [W-1:0] res_q,
   output logic         carry_q
);
   localparam logic [W:0] MOD_VAL = (W+1)'(1) << W;

   logic [W:0] sum;

   always_comb begin
      sum = {1'b0, res_q} + addend;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q   <= '0;
         carry_q <= 1'b0;
      end else if (en) begin
         res_q   <= sum[W-1:0];
         carry_q <= sum[W];
      end
   end

   // Addend never exceeds M, so one carry per step suffices (R2, R3)
   p_addend_bound_r3: assert property (@(posedge clk) disable iff (rst)
      en |-> (addend <= MOD_VAL));

   // Idle cycles freeze the accumulator (R8)
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(res_q) && $stable(carry_q)));
endmodule

// File: rtl/mash_entry_stage.sv
module mash_entry_stage #(
   parameter int unsigned W  = 9,
   parameter int unsigned FB = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] frac,
   output logic [W-1:0] res_q,
   output logic         carry_q
);
   localparam logic [W:0] IN_MAX = ((W+1)'(1) << W) - (W+1)'(1) - (W+1)'(FB);

   logic [W:0] addend;

   generate
      if (FB == 1) begin : g_carry_in
         always_comb addend = {1'b0, frac} + {{W{1'b0}}, carry_q};
      end else begin : g_scaled
         logic [W:0] fb_term;
         always_comb begin
            fb_term = carry_q ? (W+1)'(FB) : '0;
            addend  = {1'b0, frac} + fb_term;
         end
      end
   endgenerate

   mash_acc_cell #(.W(W)) acc_i (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .addend (addend),
      .res_q  (res_q),
      .carry_q(carry_q)
   );

   // Input word must leave room for the feedback term (R2)
   p_input_range_r2: assert property (@(posedge clk) disable iff (rst)
      en |-> ({1'b0, frac} <= IN_MAX));
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
   import mash3_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      en,
   input  logic      c1,
   input  logic      c2,
   input  logic      c3,
   output mash_out_t out_q
);
   logic c1_d1, c1_d2, c2_d1, c2_d2, c3_d1, c3_d2;
   logic [4:0] comb_sum;

   always_comb begin
      comb_sum = 5'(c1_d2) + 5'(c2_d1) - 5'(c2_d2)
               + 5'(c3) - 5'({c3_d1, 1'b0}) + 5'(c3_d2);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         c1_d1 <= 1'b0; c1_d2 <= 1'b0;
         c2_d1 <= 1'b0; c2_d2 <= 1'b0;
         c3_d1 <= 1'b0; c3_d2 <= 1'b0;
         out_q <= '0;
      end else if (en) begin
         c1_d1 <= c1;    c1_d2 <= c1_d1;
         c2_d1 <= c2;    c2_d2 <= c2_d1;
         c3_d1 <= c3;    c3_d2 <= c3_d1;
         out_q <= mash_out_t'(comb_sum[OUT_W-1:0]);
      end
   end

   // Output stays within the combined carry range (R4)
   p_out_range_r4: assert property (@(posedge clk) disable iff (rst)
      (out_q >= -4'sd3) && (out_q <= 4'sd4));

   // Output frozen while disabled (R8)
   p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(out_q));
endmodule

// File: rtl/mash3_spur_mod.sv
module mash3_spur_mod
   import mash3_pkg::*;
#(
   parameter int unsigned FRAC_W   = 9,
   parameter int unsigned FB_CONST = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [FRAC_W-1:0] frac_word,
   output logic [OUT_W-1:0]  mod_out
);
   localparam int unsigned MOD_VAL = 1 << FRAC_W;

   generate
      if (FRAC_W < 3 || FRAC_W > 30) begin : g_bad_width
         $error("mash3_spur_mod: FRAC_W out of range");
      end
      if (FB_CONST < 1 || FB_CONST >= MOD_VAL / 2) begin : g_bad_fb
         $error("mash3_spur_mod: FB_CONST out of range");
      end
   endgenerate

   logic [FRAC_W-1:0] res   [STAGES];
   logic              carry [STAGES];
   mash_out_t         out_s;

   mash_entry_stage #(.W(FRAC_W), .FB(FB_CONST)) entry_i (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .frac   (frac_word),
      .res_q  (res[0]),
      .carry_q(carry[0])
   );

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_chain
         logic [FRAC_W:0] link;
         always_comb link = {1'b0, res[i-1]} + {{FRAC_W{1'b0}}, carry[i-1]};
         mash_acc_cell #(.W(FRAC_W)) cell_i (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .addend (link),
            .res_q  (res[i]),
            .carry_q(carry[i])
         );
      end
   endgenerate

   mash_cancel cancel_i (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .c1   (carry[0]),
      .c2   (carry[1]),
      .c3   (carry[2]),
      .out_q(out_s)
   );

   assign mod_out = out_s;

   // Zero input from an all-zero state keeps the output at zero (R7)
   p_zero_stays_r7: assert property (@(posedge clk) disable iff (rst)
      (en && frac_word == '0 && res[0] == '0 && !carry[0] && res[1] == '0
       && !carry[1] && res[2] == '0 && !carry[2] && out_s == '0)
      |=> (out_s == '0));
endmodule

// File: tb/mash3_spur_mod_tb.sv
module mash3_spur_mod_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W   = 5;
   localparam int FB  = 3;
   localparam int M   = 1 << W;
   localparam int PER = M * M * (M - FB);
   localparam int WATCHDOG = 190000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [W-1:0] frac_word = '0;
   logic [3:0] mod_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int range_bad = 0;

   mash3_spur_mod #(.FRAC_W(W), .FB_CONST(FB)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .frac_word(frac_word),
      .mod_out  (mod_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
            summary();
         end
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int outv();
      return int'($signed(mod_out));
   endfunction

   // One enabled step; returns the output after the edge
   task automatic step(output int y);
      en = 1'b1;
      @(posedge clk); #1;
      y = outv();
      if (y < -3 || y > 4) range_bad++;
   endtask

   task automatic do_reset(input int n);
      rst = 1'b1; en = 1'b0;
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
      rst = 1'b0;
   endtask

   function automatic int unsigned mix(input int unsigned h, input int y);
      return (h * 33) ^ int'(y + 4);
   endfunction

   initial begin
      int y;
      int unsigned h0, h2, h3;
      longint s3, sw;
      int held;
      #1;
      frac_word = 5'd13;
      do_reset(3);
      // R1: reset state
      check("R1 reset output", outv(), 0);

      h0 = 0;
      for (int k = 0; k < 24; k++) begin step(y); h0 = mix(h0, y); end
      for (int k = 24; k < PER; k++) step(y);

      // second period with a pause in the middle (R8)
      h2 = 0;
      for (int k = 0; k < PER; k++) begin
         if (k == PER / 2) begin
            en = 1'b0;
            held = outv();
            for (int p = 0; p < 6; p++) begin
               @(posedge clk); #1;
               check("R8 output held while disabled", outv(), held);
            end
         end
         step(y); h2 = mix(h2, y);
      end
      h3 = 0; s3 = 0;
      for (int k = 0; k < PER; k++) begin step(y); h3 = mix(h3, y); s3 += y; end
      // R3, R5, R8: sequence repeats, unaffected by the pause
      check("R3/R5/R8 period repeat", h3, h2);
      // R6: exact sum over a full period
      check("R6 period sum", s3, 13 * M * M);

      // R9 and R1: reset in mid-run restarts identical sequence
      do_reset(2);
      check("R1 output after mid-run reset", outv(), 0);
      h3 = 0;
      for (int k = 0; k < 24; k++) begin step(y); h3 = mix(h3, y); end
      check("R9 restart sequence", h3, h0);

      // R7: zero input
      frac_word = '0;
      do_reset(2);
      held = 0;
      for (int k = 0; k < 500; k++) begin step(y); if (y != 0) held++; end
      check("R7 nonzero outputs with zero input", held, 0);

      // R2, R6: largest accepted input, window average
      frac_word = 5'(M - 1 - FB);
      do_reset(2);
      sw = 0;
      for (int k = 0; k < 4000; k++) begin step(y); sw += y; end
      sw = sw * (M - FB) - longint'(M - 1 - FB) * 4000;
      if (sw < 0) sw = -sw;
      check("R2/R6 max input average within 8M", (sw <= 8 * M) ? 1 : 0, 1);

      // R6: small input average
      frac_word = 5'd1;
      do_reset(2);
      sw = 0;
      for (int k = 0; k < 4000; k++) begin step(y); sw += y; end
      sw = sw * (M - FB) - 4000;
      if (sw < 0) sw = -sw;
      check("R6 small input average within 8M", (sw <= 8 * M) ? 1 : 0, 1);

      // R4: every sampled output in range
      check("R4 outputs outside -3..4", range_bad, 0);

      en = 1'b0;
      summary();
   end
endmodule